// File: doc/BRIEF.md
# Instruction Address Compare Debug Unit

The unit watches the address of every instruction that the pipeline is about to execute and raises debug events when that address meets a programmed condition. It has four compare registers. Each has an enable bit and a sticky status bit. The registers are grouped in two pairs (0/1 and 2/3), and each pair has a 2-bit mode field. In exact mode, each register of the pair matches on its own address. In the two range modes, the pair describes one half-open address interval, and a pair match is then reported only through the enabled members of that pair.

Software programs the unit through a small register write port. Addresses 0 to 3 hold the compare values. Address 4 holds the enables and the pair modes. Address 5 clears status bits: a one in a data bit clears that status bit. Status bits stay set until cleared. A single-cycle event output marks every cycle in which at least one status bit goes from clear to set.

Top module: `iac_debug_unit`

## Requirements
- R1: After reset every compare value, enable, mode field and status bit is zero, `event_o` is low, and instruction attempts raise no event until the unit is programmed.
- R2: In mode 2'b00, compare register k sets status bit k when its value equals the instruction address. The control word at address 4 holds enable k in bit k, the mode of pair 0/1 in bits [5:4] and the mode of pair 2/3 in bits [7:6].
- R3: A compare whose enable bit is clear never sets its status bit.
- R4: In mode 2'b10 a pair matches when lower <= address < upper. The lower bound is the even register and is included. The upper bound is the odd register and is excluded.
- R5: On a range match, each status bit of the pair is set only if its own enable is set, so one bit, the other, or both may be set.
- R6: A pair in a range mode with neither of its enables set produces no status bit and no event.
- R7: In mode 2'b11 a pair matches when the address lies outside the interval [lower, upper).
- R8: Mode 2'b01 behaves as exact compare.
- R9: Comparisons are unsigned and use address bits [31:2]; the two low address bits are ignored.
- R10: Addresses are compared only in a cycle in which `ivalid_i` is high.
- R11: Status bits are sticky. A write to address 5 clears each status bit whose data bit is one. A match in the same cycle as the clear sets the bit, so the set wins.
- R12: `event_o` is high for exactly the one cycle in which one or more status bits change from 0 to 1. A match on a bit that is already set raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0-3 compare, 4 control, 5 status clear) |
| wr_data_i | input | 32 | Register write data |
| ivalid_i | input | 1 | Instruction attempt valid |
| iaddr_i | input | 32 | Instruction address |
| status_o | output | 4 | Sticky status bits, one for each compare |
| event_o | output | 1 | One-cycle pulse when a status bit is newly set |

## Verification
Each fault inside the unit appears at the ports one clock edge after the instruction attempt that exposes it. A wrong compare value, enable or mode shows up as a missing or unexpected bit in `status_o`, together with a wrong `event_o` in that same cycle. A wrong status register appears as a bit that drops without a clear or stays set through a clear, or as an event pulse that is repeated or missing on the next attempt. Because the status bits are sticky, a spurious set stays visible until software clears it. This lets the bench sample the result one cycle after each attempt.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int unsigned IAC_ADDR_W  = 32;
  localparam int unsigned IAC_NUM_CMP = 4;
  localparam int unsigned IAC_REG_AW  = 3;
  localparam int unsigned IAC_LSB     = 2;

  typedef enum logic [1:0] {
    MODE_EXACT     = 2'b00,
    MODE_RSVD      = 2'b01,
    MODE_RANGE_IN  = 2'b10,
    MODE_RANGE_OUT = 2'b11
  } pair_mode_e;
endpackage

// File: rtl/iac_cfg_regs.sv
module iac_cfg_regs
  import iac_pkg::*;
#(
  parameter int unsigned ADDR_W  = IAC_ADDR_W,
  parameter int unsigned NUM_CMP = IAC_NUM_CMP,
  parameter int unsigned REG_AW  = IAC_REG_AW,
  localparam int unsigned WORD_W   = ADDR_W - IAC_LSB,
  localparam int unsigned NUM_PAIR = NUM_CMP / 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [REG_AW-1:0]              wr_addr_i,
  input  logic [ADDR_W-1:0]              wr_data_i,
  output logic [NUM_CMP-1:0][WORD_W-1:0] cmp_o,
  output logic [NUM_CMP-1:0]             en_o,
  output logic [NUM_PAIR-1:0][1:0]       mode_o,
  output logic [NUM_CMP-1:0]             clr_o
);
  localparam logic [REG_AW-1:0] CTRL_ADDR = REG_AW'(NUM_CMP);
  localparam logic [REG_AW-1:0] STAT_ADDR = REG_AW'(NUM_CMP + 1);

  logic ctrl_we;
  assign ctrl_we = wr_en_i && (wr_addr_i == CTRL_ADDR);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cmp_o[k] <= '0;
      else if (wr_en_i && wr_addr_i == REG_AW'(k))
        cmp_o[k] <= wr_data_i[ADDR_W-1:IAC_LSB];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      en_o <= '0;
    else if (ctrl_we)
      en_o <= wr_data_i[NUM_CMP-1:0];
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_o[p] <= MODE_EXACT;
      else if (ctrl_we)
        mode_o[p] <= wr_data_i[NUM_CMP + 2*p +: 2];
    end
  end

  assign clr_o = (wr_en_i && wr_addr_i == STAT_ADDR) ? wr_data_i[NUM_CMP-1:0] : '0;

  // R1
  ctrl_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o != $past(en_o)) |-> $past(ctrl_we));
endmodule

// File: rtl/iac_pair_cmp.sv
module iac_pair_cmp
  import iac_pkg::*;
#(
  parameter int unsigned WORD_W = IAC_ADDR_W - IAC_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic [1:0]        en_i,
  input  logic [1:0]        mode_i,
  output logic [1:0]        hit_o
);
  pair_mode_e mode;
  logic       in_range;
  logic [1:0] raw;

  assign mode     = pair_mode_e'(mode_i);
  assign in_range = (lo_i <= addr_i) && (addr_i < hi_i);

  always_comb begin
    unique case (mode)
      MODE_RANGE_IN:  raw = {2{in_range}};
      MODE_RANGE_OUT: raw = {2{!in_range}};
      default:        raw = {addr_i == hi_i, addr_i == lo_i};
    endcase
  end

  assign hit_o = valid_i ? (raw & en_i) : 2'b00;

  // R6
  range_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && en_i == 2'b00) |-> (hit_o == 2'b00));
  // R10
  hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o != 2'b00) |-> valid_i);
endmodule

// File: rtl/iac_status.sv
module iac_status
  import iac_pkg::*;
#(
  parameter int unsigned NUM_CMP = IAC_NUM_CMP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CMP-1:0] hit_i,
  input  logic [NUM_CMP-1:0] clr_i,
  output logic [NUM_CMP-1:0] status_o,
  output logic               event_o
);
  logic [NUM_CMP-1:0] fresh;
  assign fresh = hit_i & ~status_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      event_o  <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_i) | hit_i;  // set wins over clear
      event_o  <= |fresh;
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
    // R11
    no_silent_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o[i]) |-> $past(clr_i[i]));
  end

  // R12
  event_marks_new_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> ((status_o & ~$past(status_o)) != '0));
endmodule

// File: rtl/iac_debug_unit.sv
module iac_debug_unit
  import iac_pkg::*;
#(
  parameter int unsigned ADDR_W  = IAC_ADDR_W,
  parameter int unsigned NUM_CMP = IAC_NUM_CMP,
  parameter int unsigned REG_AW  = IAC_REG_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_AW-1:0]  wr_addr_i,
  input  logic [ADDR_W-1:0]  wr_data_i,
  input  logic               ivalid_i,
  input  logic [ADDR_W-1:0]  iaddr_i,
  output logic [NUM_CMP-1:0] status_o,
  output logic               event_o
);
  localparam int unsigned WORD_W   = ADDR_W - IAC_LSB;
  localparam int unsigned NUM_PAIR = NUM_CMP / 2;

  logic [NUM_CMP-1:0][WORD_W-1:0] cmp;
  logic [NUM_CMP-1:0]             en;
  logic [NUM_PAIR-1:0][1:0]       mode;
  logic [NUM_CMP-1:0]             clr;
  logic [NUM_CMP-1:0]             hit;

  iac_cfg_regs #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cmp_o(cmp), .en_o(en), .mode_o(mode), .clr_o(clr)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    iac_pair_cmp #(.WORD_W(WORD_W)) u_cmp (
      .clk_i, .rst_ni,
      .valid_i(ivalid_i),
      .addr_i (iaddr_i[ADDR_W-1:IAC_LSB]),
      .lo_i   (cmp[2*p]),
      .hi_i   (cmp[2*p+1]),
      .en_i   (en[2*p +: 2]),
      .mode_i (mode[p]),
      .hit_o  (hit[2*p +: 2])
    );
  end

  iac_status #(.NUM_CMP(NUM_CMP)) u_status (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(clr), .status_o, .event_o
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_top_chk
    // R3
    set_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[i]) |-> $past(en[i]));
  end

  // R10
  set_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~$past(status_o)) != '0 |-> $past(ivalid_i));
endmodule

// File: tb/tb_iac_debug_unit.sv
module tb_iac_debug_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        ivalid_i = 1'b0;
  logic [31:0] iaddr_i = '0;
  logic [3:0]  status_o;
  logic        event_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  iac_debug_unit dut (.*);

  // {ctrl[7:0], addr[31:0], status[3:0], event}
  localparam int VEC_N = 17;
  localparam logic [44:0] VEC [VEC_N] = '{
    {8'h0F, 32'h0000_1000, 4'b0001, 1'b1},  // R2
    {8'h0F, 32'h0000_2000, 4'b0010, 1'b1},  // R2
    {8'h0F, 32'h0000_1003, 4'b0001, 1'b1},  // R9 low bits
    {8'h0E, 32'h0000_1000, 4'b0000, 1'b0},  // R3
    {8'h23, 32'h0000_1000, 4'b0011, 1'b1},  // R4 lower incl
    {8'h23, 32'h0000_1FFC, 4'b0011, 1'b1},  // R4
    {8'h23, 32'h0000_2000, 4'b0000, 1'b0},  // R4 upper excl
    {8'h21, 32'h0000_1800, 4'b0001, 1'b1},  // R5
    {8'h22, 32'h0000_1800, 4'b0010, 1'b1},  // R5
    {8'h20, 32'h0000_1800, 4'b0000, 1'b0},  // R6
    {8'h33, 32'h0000_2000, 4'b0011, 1'b1},  // R7
    {8'h33, 32'h0000_1800, 4'b0000, 1'b0},  // R7
    {8'h13, 32'h0000_1000, 4'b0001, 1'b1},  // R8
    {8'h13, 32'h0000_1800, 4'b0000, 1'b0},  // R8
    {8'h8C, 32'h9000_0000, 4'b1100, 1'b1},  // R9 unsigned
    {8'h8C, 32'h0000_3FFC, 4'b0000, 1'b0},  // R9
    {8'h4C, 32'h0000_4000, 4'b0100, 1'b1}   // R8 pair 2/3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic attempt(input logic [31:0] a);
    @(negedge clk_i);
    ivalid_i = 1'b1; iaddr_i = a;
    @(negedge clk_i);
    ivalid_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 status", 32'(status_o), 0);
    chk("R1 event", 32'(event_o), 0);
    attempt(32'h0);
    chk("R1 no event unprogrammed", 32'(status_o), 0);

    wr(3'd0, 32'h0000_1000);
    wr(3'd1, 32'h0000_2000);
    wr(3'd2, 32'h0000_4000);
    wr(3'd3, 32'hC000_0000);

    for (int i = 0; i < VEC_N; i++) begin
      wr(3'd5, 32'hF);
      wr(3'd4, 32'(VEC[i][44:37]));
      attempt(VEC[i][36:5]);
      chk($sformatf("vec%0d status", i), 32'(status_o), 32'(VEC[i][4:1]));
      chk($sformatf("vec%0d event", i), 32'(event_o), 32'(VEC[i][0]));
    end

    // R10: no compare without valid
    wr(3'd5, 32'hF);
    wr(3'd4, 32'h0F);
    @(negedge clk_i);
    iaddr_i = 32'h1000;
    @(negedge clk_i);
    chk("R10 status", 32'(status_o), 0);
    chk("R10 event", 32'(event_o), 0);

    // R11 / R12: sticky, pulse length, no repeat event
    attempt(32'h1000);
    chk("R12 pulse", 32'(event_o), 1);
    @(negedge clk_i);
    chk("R12 one cycle", 32'(event_o), 0);
    repeat (3) @(negedge clk_i);
    chk("R11 sticky", 32'(status_o), 32'h1);
    attempt(32'h1000);
    chk("R12 no repeat", 32'(event_o), 0);
    attempt(32'h2000);
    chk("R12 new bit", 32'(event_o), 1);
    chk("R11 both set", 32'(status_o), 32'h3);
    wr(3'd5, 32'h1);
    chk("R11 partial clear", 32'(status_o), 32'h2);

    // R11: set wins over clear in same cycle
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'd5; wr_data_i = 32'hF;
    ivalid_i = 1'b1; iaddr_i = 32'h1000;
    @(negedge clk_i);
    wr_en_i = 1'b0; ivalid_i = 1'b0;
    chk("R11 set wins", 32'(status_o), 32'h1);
    chk("R12 event on set-wins", 32'(event_o), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule